// File: doc/BRIEF.md
# Address/Data Register Write Router

This block sits behind the special registers of a small command microcontroller that streams register writes into a graphics engine. The firmware loads a target address into one of two address registers (a normal one and a user one) and then writes values to a data register. Each data write is routed, one clock later, to either a GPU register or a pipe register. The value in the active address register decides where it goes. After the write, the address steps forward, so a burst of data writes fills consecutive targets.

An address up to 0xFFFF names a GPU register, and the address then advances by one. A larger address names a pipe register, and its index sits in the top byte. In this case the address advances by stepping only the top byte, and the carry out of that byte is dropped. Bit 18 holds the address still so the same pipe register can be written repeatedly. A pipe address with any other bit set is rejected. An address write that names a pipe register flagged "void" by a parameter fires a zero write to that register at once.

Three pipe registers form a memory-write channel. Two of them load the low and high halves of a 64-bit byte address. The third emits a memory write at that address and then advances the address by 4.

A two-state machine records which address register is active. In state `ST_NORM` the normal address register is used; in state `ST_USER` the user one is used. A write to the normal address register takes any state to `ST_NORM` (transition "select normal"). A write to the user address register takes any state to `ST_USER` (transition "select user"). Every other input leaves the state as it is.

Top module: `addr_data_port`

## Requirements
- R1: After reset both address registers read zero, the normal address register is active, and no write, memory or error output is asserted.
- R2: Writing the normal address register (select code 1) or the user address register (select code 2) stores the value there and makes that register the source for later data writes (select code 3). The other address register is left unchanged.
- R3: A data write with an active address of 0xFFFF or less produces, on the next cycle, one GPU register write at address bits 15:0 carrying the data. The active address then increases by one, so 0xFFFF becomes 0x10000.
- R4: A data write with an active address above 0xFFFF, having only bits 31:24 and bit 18 set, produces on the next cycle one pipe register write with index address bits 31:24 and the data.
- R5: After such a pipe write the active address increases by 0x01000000, and the top byte wraps from 0xFF to 0x00 while the lower bits are kept. If bit 18 is set, the address is left unchanged.
- R6: A data write with an active address above 0xFFFF that has any bit set outside bits 31:24 and bit 18 gives a one-cycle error pulse on the next cycle. It produces no GPU, pipe or memory write and leaves both address registers unchanged.
- R7: An address register write whose value exceeds 0xFFFF and whose top byte names a pipe register flagged in the void table (default: index 0x20) produces, on the next cycle, a pipe write of zero to that index.
- R8: Pipe writes to index 0x11 and index 0x12 load bits 31:0 and bits 63:32 of the memory address. A pipe write to index 0x10 emits a memory write of the data at that address, then adds 4 to the full 64-bit address.
- R9: A memory write is issued in the same cycle as the pipe write to index 0x10 that causes it.
- R10: With the write enable low, or with select code 0, the block produces no output write or error and changes neither address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| gpr_we_i | input | 1 | Special-register write strobe |
| gpr_sel_i | input | 2 | 0 none, 1 normal address, 2 user address, 3 data |
| gpr_wdata_i | input | 32 | Value written |
| addr_norm_o | output | 32 | Current normal address register |
| addr_user_o | output | 32 | Current user address register |
| gpu_we_o | output | 1 | GPU register write strobe |
| gpu_addr_o | output | 16 | GPU register address |
| gpu_wdata_o | output | 32 | GPU register data |
| pipe_we_o | output | 1 | Pipe register write strobe |
| pipe_idx_o | output | 8 | Pipe register index |
| pipe_wdata_o | output | 32 | Pipe register data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| err_o | output | 1 | Illegal pipe address on a data write |

## Verification
Two events can share a cycle. A data write that lands on the memory-data pipe register shows up on the pipe port and on the memory port in the same cycle, and that cycle also advances the memory address. The bench provokes this with back-to-back data writes to the memory-data index, using a held address and a low address word of 0xFFFFFFFC, so the second write has to show the carry into the high word. Expected items are queued separately for each port. The monitor requires both ports to fire together, with the pipe index equal to the memory-data index and the two addresses in order.

// File: rtl/adp_pkg.sv
package adp_pkg;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_ADDR    = 2'd1,
        SEL_USRADDR = 2'd2,
        SEL_DATA    = 2'd3
    } gpr_sel_e;

    typedef enum logic {
        ST_NORM = 1'b0,
        ST_USER = 1'b1
    } src_state_e;

endpackage

// File: rtl/adp_classify.sv
module adp_classify #(
    parameter int DW       = 32,
    parameter int GPU_AW   = 16,
    parameter int PIPE_IW  = 8,
    parameter int HOLD_BIT = 18
) (
    input  logic [DW-1:0]      addr_i,
    output logic               is_pipe_o,
    output logic               legal_o,
    output logic               hold_o,
    output logic [PIPE_IW-1:0] idx_o,
    output logic [DW-1:0]      next_o
);
    localparam int IDX_LSB = DW - PIPE_IW;
    localparam logic [DW-1:0] OK_MASK =
        ({DW{1'b1}} << IDX_LSB) | (DW'(1) << HOLD_BIT);

    always_comb begin
        is_pipe_o = |addr_i[DW-1:GPU_AW];
        legal_o   = (addr_i & ~OK_MASK) == '0;
        hold_o    = addr_i[HOLD_BIT];
        idx_o     = addr_i[DW-1:IDX_LSB];
        if (is_pipe_o)
            next_o = {idx_o + PIPE_IW'(1), addr_i[IDX_LSB-1:0]};
        else
            next_o = addr_i + DW'(1);
    end
endmodule

// File: rtl/adp_memwr.sv
module adp_memwr #(
    parameter int                 DW        = 32,
    parameter int                 PIPE_IW   = 8,
    parameter logic [PIPE_IW-1:0] DATA_IDX  = 8'h10,
    parameter logic [PIPE_IW-1:0] LO_IDX    = 8'h11,
    parameter logic [PIPE_IW-1:0] HI_IDX    = 8'h12,
    parameter int                 STEP      = 4,
    localparam int                MAW       = 2 * DW
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pw_valid_i,
    input  logic [PIPE_IW-1:0] pw_idx_i,
    input  logic [DW-1:0]      pw_data_i,
    output logic               mem_we_o,
    output logic [MAW-1:0]     mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o
);
    logic [MAW-1:0] maddr_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            maddr_q     <= '0;
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
        end else begin
            mem_we_o <= 1'b0;
            if (pw_valid_i) begin
                if (pw_idx_i == LO_IDX) begin
                    maddr_q[DW-1:0] <= pw_data_i;
                end else if (pw_idx_i == HI_IDX) begin
                    maddr_q[MAW-1:DW] <= pw_data_i;
                end else if (pw_idx_i == DATA_IDX) begin
                    mem_we_o    <= 1'b1;
                    mem_addr_o  <= maddr_q;
                    mem_wdata_o <= pw_data_i;
                    maddr_q     <= maddr_q + MAW'(STEP);
                end
            end
        end
    end
endmodule

// File: rtl/addr_data_port.sv
module addr_data_port
    import adp_pkg::*;
#(
    parameter int                         DW          = 32,
    parameter int                         GPU_AW      = 16,
    parameter int                         PIPE_IW     = 8,
    parameter int                         HOLD_BIT    = 18,
    parameter logic [PIPE_IW-1:0]         MEMDATA_IDX = 8'h10,
    parameter logic [PIPE_IW-1:0]         MEMLO_IDX   = 8'h11,
    parameter logic [PIPE_IW-1:0]         MEMHI_IDX   = 8'h12,
    parameter logic [(1<<PIPE_IW)-1:0]    VOID_MASK   = 256'h1_0000_0000,
    localparam int                        MAW         = 2 * DW
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               gpr_we_i,
    input  logic [1:0]         gpr_sel_i,
    input  logic [DW-1:0]      gpr_wdata_i,
    output logic [DW-1:0]      addr_norm_o,
    output logic [DW-1:0]      addr_user_o,
    output logic               gpu_we_o,
    output logic [GPU_AW-1:0]  gpu_addr_o,
    output logic [DW-1:0]      gpu_wdata_o,
    output logic               pipe_we_o,
    output logic [PIPE_IW-1:0] pipe_idx_o,
    output logic [DW-1:0]      pipe_wdata_o,
    output logic               mem_we_o,
    output logic [MAW-1:0]     mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    output logic               err_o
);
    src_state_e state_q, state_d;
    gpr_sel_e   sel;
    logic [DW-1:0] norm_q, user_q, norm_d, user_d, act_addr;

    logic               ac_pipe, ac_legal, ac_hold;
    logic [PIPE_IW-1:0] ac_idx;
    logic [DW-1:0]      ac_next;
    logic               wc_pipe, wc_legal, wc_hold;
    logic [PIPE_IW-1:0] wc_idx;
    logic [DW-1:0]      wc_next;

    logic               pw_valid, gw_valid, err_d;
    logic [PIPE_IW-1:0] pw_idx;
    logic [DW-1:0]      pw_data;

    assign sel      = gpr_sel_e'(gpr_sel_i);
    assign act_addr = (state_q == ST_USER) ? user_q : norm_q;

    adp_classify #(.DW(DW), .GPU_AW(GPU_AW), .PIPE_IW(PIPE_IW), .HOLD_BIT(HOLD_BIT))
    u_cls_act (
        .addr_i(act_addr), .is_pipe_o(ac_pipe), .legal_o(ac_legal),
        .hold_o(ac_hold), .idx_o(ac_idx), .next_o(ac_next)
    );

    adp_classify #(.DW(DW), .GPU_AW(GPU_AW), .PIPE_IW(PIPE_IW), .HOLD_BIT(HOLD_BIT))
    u_cls_wr (
        .addr_i(gpr_wdata_i), .is_pipe_o(wc_pipe), .legal_o(wc_legal),
        .hold_o(wc_hold), .idx_o(wc_idx), .next_o(wc_next)
    );

    // State register: which address register feeds data writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_NORM;
        else         state_q <= state_d;
    end

    // Next state and output decisions.
    always_comb begin
        state_d  = state_q;
        norm_d   = norm_q;
        user_d   = user_q;
        pw_valid = 1'b0;
        pw_idx   = '0;
        pw_data  = '0;
        gw_valid = 1'b0;
        err_d    = 1'b0;
        if (gpr_we_i) begin
            unique case (sel)
                SEL_ADDR, SEL_USRADDR: begin
                    if (sel == SEL_ADDR) begin
                        state_d = ST_NORM;
                        norm_d  = gpr_wdata_i;
                    end else begin
                        state_d = ST_USER;
                        user_d  = gpr_wdata_i;
                    end
                    if (wc_pipe && VOID_MASK[wc_idx]) begin
                        pw_valid = 1'b1;
                        pw_idx   = wc_idx;
                    end
                end
                SEL_DATA: begin
                    if (ac_pipe && !ac_legal) begin
                        err_d = 1'b1;
                    end else begin
                        if (ac_pipe) begin
                            pw_valid = 1'b1;
                            pw_idx   = ac_idx;
                            pw_data  = gpr_wdata_i;
                        end else begin
                            gw_valid = 1'b1;
                        end
                        if (!(ac_pipe && ac_hold)) begin
                            if (state_q == ST_USER) user_d = ac_next;
                            else                    norm_d = ac_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            norm_q       <= '0;
            user_q       <= '0;
            gpu_we_o     <= 1'b0;
            gpu_addr_o   <= '0;
            gpu_wdata_o  <= '0;
            pipe_we_o    <= 1'b0;
            pipe_idx_o   <= '0;
            pipe_wdata_o <= '0;
            err_o        <= 1'b0;
        end else begin
            norm_q       <= norm_d;
            user_q       <= user_d;
            gpu_we_o     <= gw_valid;
            gpu_addr_o   <= act_addr[GPU_AW-1:0];
            gpu_wdata_o  <= gpr_wdata_i;
            pipe_we_o    <= pw_valid;
            pipe_idx_o   <= pw_idx;
            pipe_wdata_o <= pw_data;
            err_o        <= err_d;
        end
    end

    assign addr_norm_o = norm_q;
    assign addr_user_o = user_q;

    adp_memwr #(
        .DW(DW), .PIPE_IW(PIPE_IW), .DATA_IDX(MEMDATA_IDX),
        .LO_IDX(MEMLO_IDX), .HI_IDX(MEMHI_IDX), .STEP(4)
    ) u_mem (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .pw_valid_i(pw_valid), .pw_idx_i(pw_idx), .pw_data_i(pw_data),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    logic unused_ok;
    assign unused_ok = ^{wc_legal, wc_hold, wc_next};
endmodule

// File: rtl/adp_checker.sv
module adp_checker #(
    parameter int                 DW          = 32,
    parameter int                 PIPE_IW     = 8,
    parameter logic [PIPE_IW-1:0] MEMDATA_IDX = 8'h10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               gpr_we_i,
    input logic [1:0]         gpr_sel_i,
    input logic [DW-1:0]      addr_norm_o,
    input logic [DW-1:0]      addr_user_o,
    input logic               gpu_we_o,
    input logic               pipe_we_o,
    input logic [PIPE_IW-1:0] pipe_idx_o,
    input logic               mem_we_o,
    input logic               err_o
);
    a_r6_err_blocks_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !gpu_we_o && !pipe_we_o && !mem_we_o);

    a_r6_err_keeps_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $stable(addr_norm_o) && $stable(addr_user_o));

    a_r9_mem_with_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> pipe_we_o && pipe_idx_o == MEMDATA_IDX);

    a_r4_gpu_pipe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gpu_we_o |-> !pipe_we_o && !err_o);

    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gpr_we_i || gpr_sel_i == 2'd0) |=>
            !gpu_we_o && !pipe_we_o && !mem_we_o && !err_o
            && $stable(addr_norm_o) && $stable(addr_user_o));
endmodule

bind addr_data_port adp_checker #(
    .DW(DW), .PIPE_IW(PIPE_IW), .MEMDATA_IDX(MEMDATA_IDX)
) u_adp_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .gpr_we_i(gpr_we_i), .gpr_sel_i(gpr_sel_i),
    .addr_norm_o(addr_norm_o), .addr_user_o(addr_user_o),
    .gpu_we_o(gpu_we_o), .pipe_we_o(pipe_we_o), .pipe_idx_o(pipe_idx_o),
    .mem_we_o(mem_we_o), .err_o(err_o)
);

// File: tb/addr_data_port_tb_top.sv
`timescale 1ns/1ps
module addr_data_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] a_norm, a_user;
    logic        gpu_we, pipe_we, mem_we, err;
    logic [15:0] gpu_addr;
    logic [31:0] gpu_wdata, pipe_wdata, mem_wdata;
    logic [7:0]  pipe_idx;
    logic [63:0] mem_addr;

    int n_run = 0, n_fail = 0;
    bit mon_on = 0, done = 0;

    logic [95:0] q_gpu[$], q_pipe[$], q_mem[$];
    string t_gpu[$], t_pipe[$], t_mem[$], t_err[$];

    logic [31:0] m_norm = 0, m_user = 0;
    logic [63:0] m_mem = 0;
    bit          m_usr = 0;

    always #2 clk = ~clk;

    addr_data_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .gpr_we_i(we), .gpr_sel_i(sel), .gpr_wdata_i(wdata),
        .addr_norm_o(a_norm), .addr_user_o(a_user),
        .gpu_we_o(gpu_we), .gpu_addr_o(gpu_addr), .gpu_wdata_o(gpu_wdata),
        .pipe_we_o(pipe_we), .pipe_idx_o(pipe_idx), .pipe_wdata_o(pipe_wdata),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .err_o(err)
    );

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of pipe-register side effects.
    task automatic model_pipe(logic [7:0] idx, logic [31:0] d, string tag);
        q_pipe.push_back({56'h0, idx, d}); t_pipe.push_back(tag);
        if (idx == 8'h11) m_mem[31:0] = d;
        else if (idx == 8'h12) m_mem[63:32] = d;
        else if (idx == 8'h10) begin
            q_mem.push_back({m_mem, d}); t_mem.push_back("R8");
            m_mem = m_mem + 64'd4;
        end
    endtask

    // Driver: computes expected items, then presents one write for one cycle.
    task automatic wr(logic [1:0] s, logic [31:0] d, bit en = 1);
        logic [31:0] a;
        if (en) begin
            if (s == 2'd1 || s == 2'd2) begin
                if (s == 2'd1) begin m_norm = d; m_usr = 0; end
                else           begin m_user = d; m_usr = 1; end
                if (d > 32'hFFFF && d[31:24] == 8'h20) model_pipe(d[31:24], 32'h0, "R7");
            end else if (s == 2'd3) begin
                a = m_usr ? m_user : m_norm;
                if (a > 32'hFFFF) begin
                    if ((a & ~32'hFF04_0000) != 0) t_err.push_back("R6");
                    else begin
                        model_pipe(a[31:24], d, a[18] ? "R5" : "R4");
                        if (!a[18]) a[31:24] = a[31:24] + 8'd1;
                    end
                end else begin
                    q_gpu.push_back({48'h0, a[15:0], d}); t_gpu.push_back(m_usr ? "R2/R3" : "R3");
                    a = a + 1;
                end
                if (!((a > 32'hFFFF) && ((a & ~32'hFF04_0000) != 0) && (a == (m_usr ? m_user : m_norm)))) begin
                    if (m_usr) m_user = a; else m_norm = a;
                end
            end
        end
        @(negedge clk);
        we = en; sel = s; wdata = d;
    endtask

    task automatic idle(int n);
        @(negedge clk); we = 0; sel = 0; wdata = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_addrs(string tag);
        chk(tag, {32'h0, a_norm, a_user}, {32'h0, m_norm, m_user});
    endtask

    // Monitor: pops expected items as the ports fire.
    always @(negedge clk) begin
        if (mon_on) begin
            if (gpu_we) begin
                if (q_gpu.size() == 0) chk("R10 unexpected gpu", 96'h1, 96'h0);
                else chk(t_gpu.pop_front(), {48'h0, gpu_addr, gpu_wdata}, q_gpu.pop_front());
            end
            if (pipe_we) begin
                if (q_pipe.size() == 0) chk("R10 unexpected pipe", 96'h1, 96'h0);
                else chk(t_pipe.pop_front(), {56'h0, pipe_idx, pipe_wdata}, q_pipe.pop_front());
            end
            if (mem_we) begin
                chk("R9", {95'h0, pipe_we && pipe_idx == 8'h10}, 96'h1);
                if (q_mem.size() == 0) chk("R8 unexpected mem", 96'h1, 96'h0);
                else chk(t_mem.pop_front(), {mem_addr, mem_wdata}, q_mem.pop_front());
            end
            if (err) begin
                if (t_err.size() == 0) chk("R6 unexpected err", 96'h1, 96'h0);
                else chk(t_err.pop_front(), 96'h1, 96'h1);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {32'h0, a_norm, a_user}, 96'h0);
        chk("R1", {92'h0, gpu_we, pipe_we, mem_we, err}, 96'h0);

        // R3 GPU burst via normal address
        wr(1, 32'h100); wr(3, 32'hA); wr(3, 32'hB); idle(2);
        chk_addrs("R3");
        // R2 user address selection
        wr(2, 32'h2000); wr(3, 32'hC); idle(2);
        chk_addrs("R2");
        wr(1, 32'h300); wr(3, 32'hD); idle(2);
        chk_addrs("R2");

        // R4 / R5 pipe increment, hold, wrap
        wr(1, 32'h0500_0000); wr(3, 32'h11); wr(3, 32'h22); idle(2);
        chk_addrs("R5");
        wr(1, 32'h0704_0000); wr(3, 32'h33); wr(3, 32'h44); idle(2);
        chk_addrs("R5");
        wr(2, 32'hFF00_0000); wr(3, 32'h55); idle(2);
        chk_addrs("R5");

        // R6 illegal pipe addresses
        wr(1, 32'h0500_0001); wr(3, 32'h66); idle(2);
        chk_addrs("R6");
        wr(1, 32'hFFFF); wr(3, 32'h77); wr(3, 32'h88); idle(2);
        chk_addrs("R6");

        // R7 void index fires a zero write; non-void does not
        wr(1, 32'h2000_0000); wr(3, 32'h99); idle(2);
        wr(2, 32'h2100_0000); idle(2);
        chk_addrs("R7");

        // R8 / R9 memory channel with carry into the high word
        wr(1, 32'h1100_0000); wr(3, 32'hFFFF_FFFC); wr(3, 32'h1);
        wr(1, 32'h1004_0000); wr(3, 32'hCAFE_0001); wr(3, 32'hCAFE_0002); idle(2);
        chk_addrs("R8");

        // R10 ignored writes
        wr(3, 32'h1234, 0); wr(0, 32'h5678); wr(1, 32'h0900_0000, 0); idle(3);
        chk_addrs("R10");

        idle(3);
        chk("R10 drained", 96'(q_gpu.size() + q_pipe.size() + q_mem.size() + t_err.size()), 96'h0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule